// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a synchronous host with a valid/ready request port to an asynchronous 16-bit DRAM that has a multiplexed row/column address. Each host request carries a word address, write data, a read/write flag and two byte enables. The controller splits the address into a row half and a column half. It sequences the RAS, the two byte CAS strobes, WE and OE, and it controls the output enable of the shared data bus. Read data returns as a one-cycle response pulse.

After an access the row stays open. When the next request targets the same row, the controller runs a page-mode column cycle and does not reopen the row. When the next request targets a different row, the controller raises RAS, waits out the precharge time and then opens the new row. A free-running timer schedules CAS-before-RAS refresh. A due refresh takes precedence over new host requests, but an access that is already in progress always finishes first. The row is also closed before the RAS-low time reaches its limit. All timing is expressed as parameters counted in clock cycles.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, RAS, both CAS strobes, WE and OE are high, the data bus is not driven and no response is pending. After release, req_ready is 1.
- R2: Address bits [19:10] are the row and appear on dram_addr when RAS falls. Bits [9:0] are the column and appear on dram_addr when a CAS strobe falls.
- R3: Byte enable bit 0 selects the lower CAS (data bits 7:0) and bit 1 selects the upper CAS (bits 15:8). 2'b11 is a word access. 2'b00 is also served as a word access, so at least one strobe falls in every access.
- R4: A read holds WE high and OE low while CAS is low. rsp_valid is high for exactly one cycle, T_CAS cycles after CAS falls, and rsp_rdata then carries the bus data for the enabled bytes.
- R5: A write is an early write. WE is low and the data bus is driven for at least one cycle before CAS falls, and OE stays high.
- R6: A request to the row that is already open runs as a page cycle: RAS stays low and only CAS toggles.
- R7: A request to another row raises RAS, and RAS then stays high for at least T_RP cycles before it falls for the new row.
- R8: CAS falls no earlier than T_RCD cycles after RAS falls, and each CAS low pulse lasts at least T_CAS cycles.
- R9: Refresh is CAS-before-RAS. Both strobes are low for at least T_CSR cycles before RAS falls, and consecutive refreshes are at most REF_PERIOD+32 cycles and 15.6 us apart.
- R10: While a refresh sequence is in progress req_ready is 0. An access that has started always completes its full CAS pulse.
- R11: RAS never stays low for more than T_RAS_MAX cycles. The controller closes an idle open row before that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address {row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 16 | Read data |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for the data bus |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
Each result has a fixed due time after its stimulus. An accepted request opens a row on the next edge, or runs its column cycle at once when the row is already open. CAS falls T_RCD+1 cycles after RAS. The read response appears exactly T_CAS cycles after the CAS fall. A due refresh drops RAS within about twenty cycles. The bench contains a memory model that samples the pins at mid-cycle and counts the cycles between strobe edges. Each edge is compared against its minimum time, and each response is compared against the cycle in which CAS fell. Read data is compared with a shadow array that the bench keeps from the writes it issued.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
// Shared types for the page-mode DRAM controller.
package fpm_pkg;
    // Sequencer states. Pin levels are decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE,   // RAS high, precharge complete
        ST_RCD,    // RAS low, row address held
        ST_COL,    // column address and WE/data set up, CAS high
        ST_CAS,    // CAS strobes low
        ST_OPEN,   // row open, CAS high, waiting for work
        ST_PRE,    // RAS high precharge
        ST_REFC,   // refresh: CAS low ahead of RAS
        ST_REFR    // refresh: RAS low with CAS low
    } fpm_state_e;
endpackage

// File: rtl/fpm_ref_timer.sv
`timescale 1ns/1ps
// Refresh timer: raises a request every REF_PERIOD cycles and holds it
// until the sequencer acknowledges it. Assumes the service latency is much
// shorter than REF_PERIOD.
module fpm_ref_timer #(
    parameter int REF_PERIOD = 1400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic due_o
);
    localparam int TW = $clog2(REF_PERIOD + 1);

    logic [TW-1:0] tick_q;
    logic          due_q;
    logic          wrap;

    assign wrap  = (tick_q == TW'(REF_PERIOD - 1));
    assign due_o = due_q;

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    tick_q <= '0;
        else if (wrap) tick_q <= '0;
        else           tick_q <= tick_q + 1'b1;
    end

    // Due flag: set at each wrap, cleared by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)     due_q <= 1'b0;
        else if (wrap)  due_q <= 1'b1;
        else if (ack_i) due_q <= 1'b0;
    end

    // R9
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (due_q && !ack_i) |=> due_q);
endmodule

// File: rtl/fpm_page_track.sv
`timescale 1ns/1ps
// Open-row tracker: holds the open row, compares it with the incoming
// request and ages the row so that it closes before the maximum RAS-low time.
// Assumes load_i pulses on the edge where RAS falls and close_i pulses on
// the edge where it rises.
module fpm_page_track #(
    parameter int ROW_W     = 10,
    parameter int T_RAS_MAX = 1000,
    parameter int T_CAS     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ROW_W-1:0] load_row_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] cmp_row_i,
    output logic             hit_o,
    output logic             age_limit_o
);
    localparam int AW        = $clog2(T_RAS_MAX + 1);
    localparam int RAS_CLOSE = T_RAS_MAX - T_CAS - 4;

    logic [ROW_W-1:0] row_q;
    logic             valid_q;
    logic [AW-1:0]    age_q;

    assign hit_o       = valid_q && (row_q == cmp_row_i);
    assign age_limit_o = valid_q && (age_q >= AW'(RAS_CLOSE));

    // Capture the open row and track whether it is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            valid_q <= 1'b0;
        end else if (load_i) begin
            row_q   <= load_row_i;
            valid_q <= 1'b1;
        end else if (close_i) begin
            valid_q <= 1'b0;
        end
    end

    // Count cycles since the row opened; saturates.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)                       age_q <= '0;
        else if (valid_q && age_q != AW'(T_RAS_MAX)) age_q <= age_q + 1'b1;
    end

    // R11
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (age_q < AW'(T_RAS_MAX)));
endmodule

// File: rtl/fpm_seq.sv
`timescale 1ns/1ps
// Access sequencer: accepts host requests, drives the DRAM strobes and
// address from its registered state, runs page hits without reopening the
// row and inserts CAS-before-RAS refresh. All pin levels decode from state
// registers, so they change only at clock edges.
module fpm_seq #(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    parameter int DW     = 16,
    parameter int T_RCD  = 4,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 3,
    parameter int T_CSR  = 2,
    parameter int T_RASR = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DW-1:0]          req_wdata,
    input  logic [1:0]             req_be,
    output logic                   rsp_valid,
    output logic [DW-1:0]          rsp_rdata,
    input  logic                   ref_due_i,
    output logic                   ref_ack_o,
    input  logic                   row_hit_i,
    input  logic                   age_limit_i,
    output logic                   row_load_o,
    output logic [ROW_W-1:0]       row_load_val_o,
    output logic                   row_close_o,
    output logic [ROW_W-1:0]       dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_lcas_n,
    output logic                   dram_ucas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DW-1:0]          dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DW-1:0]          dram_dq_in
);
    import fpm_pkg::*;

    localparam int AW   = ROW_W + COL_W;
    localparam int M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int M2   = (T_RP > T_CSR) ? T_RP : T_CSR;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M3 > T_RASR) ? M3 : T_RASR;
    localparam int CW   = $clog2(TMAX + 1);

    fpm_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pend_q, pend_d;
    logic          lat_wr_q;
    logic [AW-1:0] lat_addr_q;
    logic [DW-1:0] lat_data_q;
    logic [1:0]    lat_be_q;
    logic          accept, cnt_zero, col_phase, rsp_fire;

    assign cnt_zero = (cnt_q == '0);
    assign req_ready = !ref_due_i &&
                       ((state_q == ST_IDLE) || (state_q == ST_OPEN && !age_limit_i));
    assign accept = req_valid && req_ready;

    // Next-state and delay-counter selection.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_zero ? '0 : cnt_q - 1'b1;
        pend_d    = pend_q;
        ref_ack_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_due_i) begin
                    state_d   = ST_REFC;
                    cnt_d     = CW'(T_CSR - 1);
                    ref_ack_o = 1'b1;
                end else if (accept) begin
                    state_d = ST_RCD;
                    cnt_d   = CW'(T_RCD - 1);
                end
            end
            ST_RCD:  if (cnt_zero) state_d = ST_COL;
            ST_COL: begin
                state_d = ST_CAS;
                cnt_d   = CW'(T_CAS - 1);
            end
            ST_CAS:  if (cnt_zero) state_d = ST_OPEN;
            ST_OPEN: begin
                if (ref_due_i || age_limit_i) begin
                    state_d = ST_PRE;
                    cnt_d   = CW'(T_RP - 1);
                    pend_d  = 1'b0;
                end else if (accept) begin
                    if (row_hit_i) begin
                        state_d = ST_COL;
                    end else begin
                        state_d = ST_PRE;
                        cnt_d   = CW'(T_RP - 1);
                        pend_d  = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (cnt_zero) begin
                    state_d = pend_q ? ST_RCD : ST_IDLE;
                    cnt_d   = CW'(T_RCD - 1);
                    pend_d  = 1'b0;
                end
            end
            ST_REFC: begin
                if (cnt_zero) begin
                    state_d = ST_REFR;
                    cnt_d   = CW'(T_RASR - 1);
                end
            end
            ST_REFR: begin
                if (cnt_zero) begin
                    state_d = ST_PRE;
                    cnt_d   = CW'(T_RP - 1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, counter and pending-miss registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    // Capture an accepted request; an empty byte mask means a word access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_wr_q   <= 1'b0;
            lat_addr_q <= '0;
            lat_data_q <= '0;
            lat_be_q   <= 2'b11;
        end else if (accept) begin
            lat_wr_q   <= req_write;
            lat_addr_q <= req_addr;
            lat_data_q <= req_wdata;
            lat_be_q   <= (req_be == 2'b00) ? 2'b11 : req_be;
        end
    end

    // Read return: sample the bus on the edge that ends the CAS pulse.
    assign rsp_fire = (state_q == ST_CAS) && cnt_zero && !lat_wr_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rsp_fire;
            if (rsp_fire) rsp_rdata <= dram_dq_in;
        end
    end

    // Row tracker hooks.
    assign row_load_o     = (state_q == ST_IDLE && state_d == ST_RCD) ||
                            (state_q == ST_PRE && state_d == ST_RCD);
    assign row_load_val_o = (state_q == ST_IDLE) ? req_addr[AW-1:COL_W]
                                                 : lat_addr_q[AW-1:COL_W];
    assign row_close_o    = (state_q == ST_OPEN) && (state_d == ST_PRE);

    // Pin decode from the registered state.
    assign col_phase = (state_q == ST_COL) || (state_q == ST_CAS);
    always_comb begin
        dram_ras_n  = !(state_q inside {ST_RCD, ST_COL, ST_CAS, ST_OPEN, ST_REFR});
        dram_lcas_n = 1'b1;
        dram_ucas_n = 1'b1;
        if (state_q == ST_CAS) begin
            dram_lcas_n = !lat_be_q[0];
            dram_ucas_n = !lat_be_q[1];
        end else if (state_q == ST_REFC || state_q == ST_REFR) begin
            dram_lcas_n = 1'b0;
            dram_ucas_n = 1'b0;
        end
        if (state_q == ST_RCD)                 dram_addr = lat_addr_q[AW-1:COL_W];
        else if (col_phase || state_q == ST_OPEN) dram_addr = lat_addr_q[COL_W-1:0];
        else                                   dram_addr = '0;
        dram_we_n   = !(col_phase && lat_wr_q);
        dram_oe_n   = !(col_phase && !lat_wr_q);
        dram_dq_oe  = col_phase && lat_wr_q;
        dram_dq_out = lat_data_q;
    end

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R5
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_we_n)
        |-> ($past(!dram_we_n) && dram_dq_oe && dram_oe_n));
    // R8
    ras_before_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_ras_n) |-> $past(!dram_ras_n));
    // R9
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_lcas_n) |-> $past(!dram_lcas_n && !dram_ucas_n));
    // R3
    strobe_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAS) |-> (!dram_lcas_n || !dram_ucas_n));
    // R10
    refresh_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFC || state_q == ST_REFR) |-> !req_ready);
endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
// Page-mode DRAM controller top: wires the sequencer, open-row tracker and
// refresh timer. Assumes a 100 MHz clock for the default cycle counts and a
// memory with a 10-bit multiplexed address and two byte column strobes.
module fpm_dram_ctrl #(
    parameter int ROW_W      = 10,
    parameter int COL_W      = 10,
    parameter int DW         = 16,
    parameter int T_RCD      = 4,
    parameter int T_CAS      = 2,
    parameter int T_RP       = 3,
    parameter int T_CSR      = 2,
    parameter int T_RASR     = 5,
    parameter int T_RAS_MAX  = 1000,
    parameter int REF_PERIOD = 1400
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DW-1:0]          req_wdata,
    input  logic [1:0]             req_be,
    output logic                   rsp_valid,
    output logic [DW-1:0]          rsp_rdata,
    output logic [ROW_W-1:0]       dram_addr,
    output logic                   dram_ras_n,
    output logic                   dram_lcas_n,
    output logic                   dram_ucas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DW-1:0]          dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DW-1:0]          dram_dq_in
);
    localparam int AW = ROW_W + COL_W;

    logic             ref_due, ref_ack, row_hit, age_limit, row_load, row_close;
    logic [ROW_W-1:0] row_load_val;

    fpm_ref_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
        .clk(clk), .rst_n(rst_n), .ack_i(ref_ack), .due_o(ref_due)
    );

    fpm_page_track #(.ROW_W(ROW_W), .T_RAS_MAX(T_RAS_MAX), .T_CAS(T_CAS)) u_track (
        .clk(clk), .rst_n(rst_n),
        .load_i(row_load), .load_row_i(row_load_val), .close_i(row_close),
        .cmp_row_i(req_addr[AW-1:COL_W]),
        .hit_o(row_hit), .age_limit_o(age_limit)
    );

    fpm_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_RP(T_RP), .T_CSR(T_CSR), .T_RASR(T_RASR)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_due_i(ref_due), .ref_ack_o(ref_ack),
        .row_hit_i(row_hit), .age_limit_i(age_limit),
        .row_load_o(row_load), .row_load_val_o(row_load_val), .row_close_o(row_close),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );
endmodule

// File: tb/sim_fpm_dram_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural DRAM model sampling pins at mid-cycle, host driver
// with directed and seeded random traffic, shadow memory for expected data.
module sim_fpm_dram_ctrl;
    localparam int T_RCD = 4, T_CAS = 2, T_RP = 3, T_CSR = 2, T_RASR = 5;
    localparam int T_RAS_MAX = 1000, REF_PERIOD = 1400;
    localparam int REF_LIMIT = REF_PERIOD + 32;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = '0;

    always #4 clk = ~clk;

    fpm_dram_ctrl #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_RASR(T_RASR),
        .T_RAS_MAX(T_RAS_MAX), .REF_PERIOD(REF_PERIOD)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // Current request as seen by the model.
    logic        cur_wr = 0;
    logic [19:0] cur_addr = '0;
    logic [1:0]  cur_be = 2'b11;

    // Model memory and bench shadow, indexed by low row and column bits.
    logic [15:0] mmem [64];
    logic [15:0] emem [64];

    function automatic int idx(input logic [19:0] a);
        return int'({a[12:10], a[2:0]});
    endfunction

    function automatic logic [1:0] eff_be(input logic [1:0] b);
        return (b == 2'b00) ? 2'b11 : b;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] b);
        return {{8{b[1]}}, {8{b[0]}}};
    endfunction

    // Model state.
    longint ncyc = 0, last_ref = 0, last_ref_t = 0, cas_fall_cyc = 0;
    int     ras_hi_cnt = 1000, ras_lo_cnt = 0, srf = 0, cas_w = 0, cas_pre = 0;
    int     ref_cnt = 0, open_cnt = 0, acc_cnt = 0;
    logic   p_ras = 1, p_l = 1, p_u = 1, p_we = 1;

    // DRAM model: checks strobe order and minimum times, stores and returns data.
    always @(negedge clk) begin
        logic anyc, panyc;
        ncyc++;
        anyc  = !dram_lcas_n || !dram_ucas_n;
        panyc = !p_l || !p_u;
        if (rst_n) begin
            if (!dram_ras_n && p_ras) begin
                if (anyc && panyc) begin
                    chk(!p_l && !p_u && !dram_lcas_n && !dram_ucas_n, "R9 both strobes ahead of RAS",
                        {dram_ucas_n, dram_lcas_n}, 0);
                    chk(cas_pre >= T_CSR, "R9 CAS lead cycles", cas_pre, T_CSR);
                    if (ref_cnt > 0) begin
                        chk(ncyc - last_ref <= REF_LIMIT, "R9 refresh spacing cycles",
                            ncyc - last_ref, REF_LIMIT);
                        chk(longint'($time) - last_ref_t <= 15600, "R9 refresh spacing ns",
                            longint'($time) - last_ref_t, 15600);
                    end
                    last_ref   = ncyc;
                    last_ref_t = longint'($time);
                    ref_cnt++;
                end else begin
                    chk(ras_hi_cnt >= T_RP, "R7 precharge cycles", ras_hi_cnt, T_RP);
                    chk(dram_addr == cur_addr[19:10], "R2 row address", dram_addr, cur_addr[19:10]);
                    open_cnt++;
                end
                ras_lo_cnt = 0;
                srf = 0;
            end
            if (dram_ras_n && !p_ras)
                chk(ras_lo_cnt <= T_RAS_MAX, "R11 RAS low cycles", ras_lo_cnt, T_RAS_MAX);
            if (anyc && !panyc && !dram_ras_n) begin
                logic [1:0] b;
                b = eff_be(cur_be);
                chk(srf >= T_RCD, "R8 RAS to CAS cycles", srf, T_RCD);
                chk(dram_addr == cur_addr[9:0], "R2 column address", dram_addr, cur_addr[9:0]);
                chk({!dram_ucas_n, !dram_lcas_n} == b, "R3 strobe selection",
                    {!dram_ucas_n, !dram_lcas_n}, b);
                if (cur_wr) begin
                    chk(!dram_we_n && !p_we && dram_oe_n && dram_dq_oe, "R5 early write setup",
                        {dram_we_n, p_we, dram_oe_n, dram_dq_oe}, 4'b0011);
                    if (!dram_lcas_n) mmem[idx(cur_addr)][7:0]  = dram_dq_out[7:0];
                    if (!dram_ucas_n) mmem[idx(cur_addr)][15:8] = dram_dq_out[15:8];
                end else begin
                    chk(dram_we_n && !dram_oe_n && !dram_dq_oe, "R4 read strobes",
                        {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b100);
                    dram_dq_in = mmem[idx(cur_addr)] & lane_mask(b);
                end
                cas_fall_cyc = ncyc;
                acc_cnt++;
            end
            if (!anyc && panyc)
                chk(cas_w >= T_CAS, "R8 CAS width cycles", cas_w, T_CAS);
            if (anyc && dram_ras_n)
                chk(!req_ready, "R10 host blocked during refresh", req_ready, 0);
            cas_w   = anyc ? cas_w + 1 : 0;
            cas_pre = (anyc && dram_ras_n) ? cas_pre + 1 : (anyc ? cas_pre : 0);
            if (!dram_ras_n) begin ras_lo_cnt++; srf++; ras_hi_cnt = 0; end
            else ras_hi_cnt++;
        end
        p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n; p_we = dram_we_n;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // One host access: waits for acceptance, the CAS fall and, for reads, the response.
    task automatic access(input bit wr, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        int t, acc0;
        logic [1:0] b;
        b = eff_be(be);
        cur_wr = wr; cur_addr = a; cur_be = be;
        req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        t = 0;
        while (!req_ready && t < 400) begin tick(); t++; end
        acc0 = acc_cnt;
        tick();
        req_valid = 1'b0;
        if (t >= 400) begin chk(0, "R10 request never accepted", 0, 1); return; end
        t = 0;
        while (acc_cnt == acc0 && t < 100) begin tick(); t++; end
        chk(acc_cnt != acc0, "R2 column cycle issued", acc_cnt, acc0 + 1);
        if (wr) begin
            if (b[0]) emem[idx(a)][7:0]  = d[7:0];
            if (b[1]) emem[idx(a)][15:8] = d[15:8];
        end else begin
            t = 0;
            while (!rsp_valid && t < 20) begin tick(); t++; end
            chk(rsp_valid && (ncyc - cas_fall_cyc == T_CAS), "R4 response cycle",
                ncyc - cas_fall_cyc, T_CAS);
            chk((rsp_rdata & lane_mask(b)) == (emem[idx(a)] & lane_mask(b)), "R4 read data",
                rsp_rdata & lane_mask(b), emem[idx(a)] & lane_mask(b));
            tick();
            chk(!rsp_valid, "R4 single-cycle response", rsp_valid, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog expired", 0, 1);
            report();
        end
    end

    initial begin
        int o0, r0;
        logic [9:0] prow;
        for (int i = 0; i < 64; i++) begin mmem[i] = '0; emem[i] = '0; end
        void'($urandom(32'h0F9A_2C41));
        repeat (3) tick();
        // R1 reset levels
        chk({dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_valid}
            == 7'b1111100, "R1 pins in reset",
            {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_valid},
            7'b1111100);
        rst_n = 1'b1;
        tick();
        chk(req_ready && dram_ras_n && dram_lcas_n && dram_ucas_n, "R1 ready after reset",
            {req_ready, dram_ras_n}, 2'b11);

        // Word, byte and empty-mask accesses (R3).
        access(1, 20'h00000, 16'hA55A, 2'b11);
        access(0, 20'h00000, 16'h0000, 2'b11);
        access(1, 20'h00000, 16'h3C77, 2'b01);
        access(0, 20'h00000, 16'h0000, 2'b11);
        access(1, 20'h00000, 16'hE100, 2'b10);
        access(0, 20'h00000, 16'h0000, 2'b10);
        access(1, 20'hFFFFF, 16'h1234, 2'b00);
        access(0, 20'hFFFFF, 16'h0000, 2'b00);

        // R7 row change: each miss opens the row again after precharge.
        o0 = open_cnt;
        access(1, 20'h0AC03, 16'hBEEF, 2'b11);
        access(0, 20'h35005, 16'h0000, 2'b11);
        chk(open_cnt - o0 == 2, "R7 row opens on miss", open_cnt - o0, 2);

        // R6 page burst right after a refresh.
        r0 = ref_cnt;
        while (ref_cnt == r0) tick();
        access(1, 20'h2A400, 16'h0101, 2'b11);
        o0 = open_cnt;
        access(1, 20'h2A401, 16'h0202, 2'b11);
        access(0, 20'h2A400, 16'h0000, 2'b11);
        access(0, 20'h2A401, 16'h0000, 2'b01);
        access(0, 20'h2A7FF, 16'h0000, 2'b11);
        chk(open_cnt == o0, "R6 burst stays in row", open_cnt - o0, 0);

        // R11 idle with row open: limit closes it; refreshes continue.
        r0 = ref_cnt;
        repeat (3000) tick();
        chk(dram_ras_n || ras_lo_cnt <= T_RAS_MAX, "R11 idle row closed", ras_lo_cnt, T_RAS_MAX);
        chk(ref_cnt - r0 >= 2, "R9 refresh while idle", ref_cnt - r0, 2);

        // Seeded random traffic with row reuse.
        prow = 10'd0;
        for (int n = 0; n < 500; n++) begin
            logic [19:0] a;
            logic [9:0]  row;
            row = ($urandom % 100 < 60) ? prow : 10'($urandom);
            a = {row, 10'($urandom)};
            prow = row;
            access(1'($urandom), a, 16'($urandom), 2'($urandom));
            repeat ($urandom % 4) tick();
        end
        chk(ref_cnt >= 5, "R9 refreshes issued", ref_cnt, 5);
        report();
    end
endmodule